// File: doc/BRIEF.md
# Floating-Point Status and Exception Resolver

This block keeps the 16-bit status word of a floating-point coprocessor and turns the raw exception indications of an arithmetic datapath into a single recorded trap code, sticky flags and per-operation control pulses. The datapath raises `op_start` when an operation begins and `op_done` together with its exception flags (and an illegal-opcode indication) when the operation ends. The block answers with a trap request, a signal that tells the result path to deliver no result words, and a signal that forces an underflowed result to zero.

Software writes the entire status word through a load strobe that carries an operand at least 16 bits wide. The rounding-mode field of the stored word goes straight to the datapath. Trap enables, sticky flags and a 7-bit software field all live in the same word. The software field is written only by a load.

Top module: `fp_status_unit`

## Requirements
- R1: While reset (synchronous, active low) is held, the status word and all three control pulses are zero.
- R2: A load replaces the whole status word with bits 15:0 of the load operand at the next clock edge. The rounding-mode output equals status bits 8:7, with the codes 0 = nearest-even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity.
- R3: An operation start clears the trap-code field (bits 2:0) and leaves bits 15:3 unchanged.
- R4: At operation end, the trap-code field takes the code of the single highest-priority exception present. The priority order, highest first, is illegal (4), underflow (1), overflow (2), divide-by-zero (3), invalid (5) and inexact (6). The field takes 0 when no exception is present. The exception flag input uses bit 0 for underflow, bit 1 for overflow, bit 2 for divide-by-zero, bit 3 for invalid and bit 4 for inexact.
- R5: A selected underflow sets the underflow flag (bit 4). If the underflow trap enable (bit 3) is set, it requests a trap. Otherwise it raises the zero-result pulse and requests no trap.
- R6: A selected overflow or divide-by-zero always requests a trap.
- R7: A selected invalid operation records code 5 and requests no trap.
- R8: A selected inexact sets the inexact flag (bit 6). It requests a trap only when the inexact trap enable (bit 5) is set.
- R9: An illegal-opcode indication at operation end records code 4 and always requests a trap. It changes neither sticky flag.
- R10: Trap request, result suppress and zero-result are one-cycle pulses in the cycle after operation end. Result suppress equals the trap request. Only the selected exception touches a sticky flag.
- R11: When strobes coincide, a load wins over an operation end, and an operation end wins over an operation start. An end that loses to a load raises no pulse.
- R12: The software field (bits 15:9) changes only on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load the status word |
| ld_data | input | LD_W | Load operand; low 16 bits are used |
| op_start | input | 1 | Operation begins |
| op_done | input | 1 | Operation ends; flags are valid |
| illegal_op | input | 1 | Operation was an illegal opcode |
| exc_flags | input | 5 | Raw exceptions: 0 underflow, 1 overflow, 2 divide-by-zero, 3 invalid, 4 inexact |
| fsr | output | 16 | Current status word |
| round_mode | output | 2 | Rounding mode for the datapath |
| trap_req | output | 1 | Trap request pulse |
| result_suppress | output | 1 | Deliver no result words |
| result_zero | output | 1 | Force the result to zero |

## Verification
The properties about the trap code and the pulses assume that the end strobe is not masked by a load in the same cycle. They exclude the load in their antecedents and do not rely on the strobes being exclusive. The randomized stimulus keeps the three strobes mutually exclusive, so every cycle has a single clear cause. Coinciding strobes appear only in a few directed cycles, and those cycles are checked against the priority rule. Flag vectors are drawn freely, so several exceptions often arrive together, and the tests cover both settings of each trap enable.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   localparam int FSR_W  = 16;
   localparam int NEXC   = 5;
   localparam int TT_W   = 3;

   typedef enum logic [TT_W-1:0] {
      TT_NONE = 3'd0,
      TT_UNF  = 3'd1,
      TT_OVF  = 3'd2,
      TT_DVZ  = 3'd3,
      TT_ILL  = 3'd4,
      TT_INV  = 3'd5,
      TT_INX  = 3'd6,
      TT_RSV  = 3'd7
   } trap_code_e;

   // bit 0 is underflow, the highest arithmetic priority
   typedef struct packed {
      logic inx;
      logic inv;
      logic dvz;
      logic ovf;
      logic unf;
   } exc_flags_t;

   typedef struct packed {
      logic [6:0] sw;
      logic [1:0] rm;
      logic       inx_flag;
      logic       inx_en;
      logic       unf_flag;
      logic       unf_en;
      trap_code_e tt;
   } fsr_t;
endpackage

// File: rtl/fpsr_prio.sv
module fpsr_prio
   import fpsr_pkg::*;
(
   input  logic       ill_i,
   input  exc_flags_t flags_i,
   output trap_code_e code_o
);
   function automatic trap_code_e rank_code(input int idx);
      case (idx)
         0:       return TT_UNF;
         1:       return TT_OVF;
         2:       return TT_DVZ;
         3:       return TT_INV;
         default: return TT_INX;
      endcase
   endfunction

   logic [NEXC-1:0] vec;
   assign vec = flags_i;

   always_comb begin
      code_o = TT_NONE;
      for (int i = NEXC-1; i >= 0; i--) begin
         if (vec[i]) code_o = rank_code(i);
      end
      if (ill_i) code_o = TT_ILL;
   end
endmodule

// File: rtl/fpsr_gate.sv
module fpsr_gate
   import fpsr_pkg::*;
(
   input  trap_code_e code_i,
   input  logic       unf_en_i,
   input  logic       inx_en_i,
   output logic       trap_o,
   output logic       zero_o
);
   always_comb begin
      trap_o = 1'b0;
      zero_o = 1'b0;
      case (code_i)
         TT_ILL, TT_OVF, TT_DVZ: trap_o = 1'b1;
         TT_UNF: begin
            trap_o = unf_en_i;
            zero_o = !unf_en_i;
         end
         TT_INX:  trap_o = inx_en_i;
         default: trap_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpsr_store.sv
module fpsr_store
   import fpsr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [FSR_W-1:0] ld_word,
   input  logic             op_start,
   input  logic             op_done,
   input  trap_code_e       code_i,
   output fsr_t             fsr_o
);
   fsr_t fsr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsr_q <= '0;
      end else if (ld_en) begin
         fsr_q <= fsr_t'(ld_word);
      end else if (op_done) begin
         fsr_q.tt <= code_i;
         if (code_i == TT_UNF) fsr_q.unf_flag <= 1'b1;
         if (code_i == TT_INX) fsr_q.inx_flag <= 1'b1;
      end else if (op_start) begin
         fsr_q.tt <= TT_NONE;
      end
   end

   assign fsr_o = fsr_q;
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
   import fpsr_pkg::*;
#(
   parameter int LD_W    = 32,
   parameter bit OUT_REG = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [LD_W-1:0]  ld_data,
   input  logic             op_start,
   input  logic             op_done,
   input  logic             illegal_op,
   input  logic [NEXC-1:0]  exc_flags,
   output logic [FSR_W-1:0] fsr,
   output logic [1:0]       round_mode,
   output logic             trap_req,
   output logic             result_suppress,
   output logic             result_zero
);
   initial begin
      assert (LD_W >= FSR_W) else $fatal(1, "LD_W must cover the status word");
   end

   trap_code_e code;
   fsr_t       fsr_cur;
   logic       gate_trap;
   logic       gate_zero;
   logic       finish;

   assign finish = op_done && !ld_en;

   fpsr_prio u_prio (
      .ill_i   (illegal_op),
      .flags_i (exc_flags_t'(exc_flags)),
      .code_o  (code)
   );

   fpsr_gate u_gate (
      .code_i   (code),
      .unf_en_i (fsr_cur.unf_en),
      .inx_en_i (fsr_cur.inx_en),
      .trap_o   (gate_trap),
      .zero_o   (gate_zero)
   );

   fpsr_store u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_word  (ld_data[FSR_W-1:0]),
      .op_start (op_start),
      .op_done  (op_done),
      .code_i   (code),
      .fsr_o    (fsr_cur)
   );

   if (LD_W > FSR_W) begin : g_wide
      logic ld_unused_hi;
      assign ld_unused_hi = ^ld_data[LD_W-1:FSR_W];
   end

   if (OUT_REG) begin : g_pulse_reg
      logic trap_q, zero_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trap_q <= 1'b0;
            zero_q <= 1'b0;
         end else begin
            trap_q <= finish && gate_trap;
            zero_q <= finish && gate_zero;
         end
      end
      assign trap_req    = trap_q;
      assign result_zero = zero_q;
   end else begin : g_pulse_comb
      assign trap_req    = finish && gate_trap;
      assign result_zero = finish && gate_zero;
   end

   assign result_suppress = trap_req;
   assign fsr             = fsr_cur;
   assign round_mode      = fsr_cur.rm;
endmodule

// File: rtl/fpsr_chk.sv
module fpsr_chk #(
   parameter bit OUT_REG = 1'b1
)(
   input logic        clk,
   input logic        rst_n,
   input logic        ld_en,
   input logic [15:0] ld_low,
   input logic        op_start,
   input logic        op_done,
   input logic        illegal_op,
   input logic [4:0]  exc_flags,
   input logic [15:0] fsr,
   input logic        trap_req,
   input logic        result_suppress,
   input logic        result_zero
);
   assert_load_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> fsr == $past(ld_low));

   assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !op_done && !ld_en) |=> (fsr[2:0] == 3'd0 && fsr[15:3] == $past(fsr[15:3])));

   assert_sw_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> fsr[15:9] == $past(fsr[15:9]));

   if (OUT_REG) begin : g_timed
      assert_always_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (op_done && !ld_en && !illegal_op && !exc_flags[0] && (exc_flags[1] || exc_flags[2]))
         |=> (trap_req && result_suppress));

      assert_zero_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
         result_zero |-> (fsr[4] && !fsr[3] && fsr[2:0] == 3'd1 && !trap_req));

      assert_invalid_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (op_done && !ld_en && !illegal_op && exc_flags == 5'b01000)
         |=> (!trap_req && fsr[2:0] == 3'd5));

      assert_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (op_done && !ld_en && illegal_op)
         |=> (trap_req && fsr[2:0] == 3'd4 && fsr[6:3] == $past(fsr[6:3])));

      assert_pulse_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (trap_req || result_zero) |-> $past(op_done && !ld_en));
   end
endmodule

bind fp_status_unit fpsr_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ld_en           (ld_en),
   .ld_low          (ld_data[15:0]),
   .op_start        (op_start),
   .op_done         (op_done),
   .illegal_op      (illegal_op),
   .exc_flags       (exc_flags),
   .fsr             (fsr),
   .trap_req        (trap_req),
   .result_suppress (result_suppress),
   .result_zero     (result_zero)
);

// File: tb/sim_fp_status_unit.sv
`timescale 1ns/1ps
module sim_fp_status_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [31:0] ld_data = '0;
   logic        op_start = 1'b0;
   logic        op_done = 1'b0;
   logic        illegal_op = 1'b0;
   logic [4:0]  exc_flags = '0;
   logic [15:0] fsr;
   logic [1:0]  round_mode;
   logic        trap_req, result_suppress, result_zero;

   int checks = 0;
   int fails = 0;
   bit armed = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fp_status_unit u0 (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
      .op_start(op_start), .op_done(op_done), .illegal_op(illegal_op),
      .exc_flags(exc_flags), .fsr(fsr), .round_mode(round_mode),
      .trap_req(trap_req), .result_suppress(result_suppress),
      .result_zero(result_zero)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference, updated on every rising edge
   int m_fsr = 0;
   bit m_trap = 0, m_zero = 0;

   always @(posedge clk) begin
      int tt;
      m_trap = 0;
      m_zero = 0;
      if (!rst_n) begin
         m_fsr = 0;
      end else if (ld_en) begin
         m_fsr = ld_data & 32'hFFFF;
      end else if (op_done) begin
         tt = 0;
         if (illegal_op) begin
            tt = 4; m_trap = 1;
         end else if (exc_flags[0]) begin
            tt = 1; m_fsr = m_fsr | 'h10;
            if (m_fsr & 'h8) m_trap = 1; else m_zero = 1;
         end else if (exc_flags[1]) begin
            tt = 2; m_trap = 1;
         end else if (exc_flags[2]) begin
            tt = 3; m_trap = 1;
         end else if (exc_flags[3]) begin
            tt = 5;
         end else if (exc_flags[4]) begin
            tt = 6; m_fsr = m_fsr | 'h40;
            if (m_fsr & 'h20) m_trap = 1;
         end
         m_fsr = (m_fsr & ~7) | tt;
      end else if (op_start) begin
         m_fsr = m_fsr & ~7;
      end
   end

   always @(negedge clk) begin
      if (armed && !finished) begin
         check("R4 status word vs model", {16'h0, fsr}, m_fsr);
         check("R2 rounding mode vs model", {30'h0, round_mode}, (m_fsr >> 7) & 3);
         check("R6 trap request vs model", {31'h0, trap_req}, m_trap);
         check("R10 result suppress vs model", {31'h0, result_suppress}, m_trap);
         check("R5 zero result vs model", {31'h0, result_zero}, m_zero);
      end
   end

   task automatic drive(input bit ld, input logic [31:0] d, input bit st, input bit dn,
                        input bit il, input logic [4:0] f);
      ld_en = ld; ld_data = d; op_start = st; op_done = dn; illegal_op = il; exc_flags = f;
      @(negedge clk);
      ld_en = 0; op_start = 0; op_done = 0; illegal_op = 0; exc_flags = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      armed = 1'b1;
      check("R1 reset status", {16'h0, fsr}, 0);
      check("R1 reset trap", {31'h0, trap_req}, 0);
      check("R1 reset zero", {31'h0, result_zero}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      drive(1, 32'hDEAD_0100, 0, 0, 0, 0);
      check("R2 load low half", {16'h0, fsr}, 32'h0100);
      check("R2 toward +inf code", {30'h0, round_mode}, 2);
      drive(1, 32'h0000_0180, 0, 0, 0, 0);
      check("R2 toward -inf code", {30'h0, round_mode}, 3);
      drive(1, 32'h0000_0080, 0, 0, 0, 0);
      check("R2 toward zero code", {30'h0, round_mode}, 1);

      drive(1, 32'h0000_FE7D, 0, 0, 0, 0);
      drive(0, 0, 1, 0, 0, 0);
      check("R3 start clears trap code only", {16'h0, fsr}, 32'hFE78);
      drive(0, 0, 0, 1, 0, 5'b10011);
      check("R4 underflow beats overflow and inexact", {29'h0, fsr[2:0]}, 1);
      check("R5 enabled underflow traps", {31'h0, trap_req}, 1);
      check("R5 enabled underflow no zeroing", {31'h0, result_zero}, 0);

      drive(1, 0, 0, 0, 0, 0);
      drive(0, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b10001);
      check("R5 masked underflow status", {16'h0, fsr}, 32'h0011);
      check("R5 masked underflow zeroes", {31'h0, result_zero}, 1);
      check("R5 masked underflow no trap", {31'h0, trap_req}, 0);
      drive(0, 0, 0, 0, 0, 0);
      check("R10 zero pulse lasts one cycle", {31'h0, result_zero}, 0);

      drive(0, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b00110);
      check("R4 overflow beats divide-by-zero", {16'h0, fsr}, 32'h0012);
      check("R6 overflow traps", {31'h0, trap_req}, 1);
      drive(0, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b01100);
      check("R4 divide-by-zero beats invalid", {16'h0, fsr}, 32'h0013);
      check("R6 divide-by-zero traps", {31'h0, trap_req}, 1);

      drive(0, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b01000);
      check("R7 invalid code", {16'h0, fsr}, 32'h0015);
      check("R7 invalid no trap", {31'h0, trap_req}, 0);

      drive(0, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b10000);
      check("R8 masked inexact sets flag", {16'h0, fsr}, 32'h0056);
      check("R8 masked inexact no trap", {31'h0, trap_req}, 0);
      drive(1, 32'h0000_0020, 0, 0, 0, 0);
      drive(0, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b10000);
      check("R8 enabled inexact status", {16'h0, fsr}, 32'h0066);
      check("R8 enabled inexact traps", {31'h0, trap_req}, 1);
      check("R10 suppress follows trap", {31'h0, result_suppress}, 1);

      drive(1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 1, 1, 5'b11111);
      check("R9 illegal code, no flags", {16'h0, fsr}, 32'h0004);
      check("R9 illegal traps", {31'h0, trap_req}, 1);

      drive(1, 32'h0000_AE00, 0, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b00010);
      check("R12 software field kept", {16'h0, fsr}, 32'hAE02);

      drive(1, 32'h0000_1234, 0, 1, 0, 5'b00010);
      check("R11 load beats end", {16'h0, fsr}, 32'h1234);
      check("R11 masked end raises no trap", {31'h0, trap_req}, 0);
      drive(0, 0, 1, 1, 0, 5'b00010);
      check("R11 end beats start", {16'h0, fsr}, 32'h1232);
      drive(0, 0, 1, 0, 0, 0);
      drive(0, 0, 0, 1, 0, 5'b00000);
      check("R4 no exception gives code 0", {16'h0, fsr}, 32'h1230);

      for (int i = 0; i < 4000; i++) begin
         int kind;
         kind = $urandom_range(0, 9);
         if (kind == 0)
            drive(1, $urandom, 0, 0, 0, 0);
         else if (kind <= 3)
            drive(0, 0, 1, 0, 0, 0);
         else if (kind <= 7)
            drive(0, 0, 0, 1, ($urandom_range(0, 9) == 0), 5'($urandom));
         else
            drive(0, 0, 0, 0, 0, 0);
      end

      finish_run();
   end
endmodule